// File: doc/BRIEF.md
# Priority-Ordered Bus Selector

This block picks one of N equal-width data buses and drives it onto a single output bus. Each bus has its own select bit with the same index. More than one select bit may be high at the same time. When that happens, the bus whose select bit has the highest index wins. When no select bit is high, the output is all zeros.

The output is purely combinational and settles in the same cycle as its inputs. Internally the block is a ripple chain of two-input bus selectors. An accumulator begins at zero. At each stage, working upward from index 0, the accumulator is replaced by that stage's bus when the stage's select bit is high. The chain therefore needs no separate priority encoder. The bus count N (at least 1) and the bus width W are parameters.

Top module: `prio_bus_sel`

## Requirements
- R1: With exactly one select bit `sel_i[k]` high, `bus_o` equals `bus_i[k]`, for every k in 0..N-1.
- R2: With several select bits high, `bus_o` equals `bus_i[k]`, where k is the highest index whose select bit is high.
- R3: With `sel_i` all zero, `bus_o` is all zero, whatever the data buses carry.
- R4: With select bit k high, the data on every bus below index k has no effect on `bus_o`.
- R5: A bus whose select bit is low has no effect on `bus_o`, including buses above the winning index.
- R6: Every bit lane of `bus_o` is steered by the same select bits, and `bus_o` follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_i | input | N x W (packed, bus k at `bus_i[k]`) | Data buses, one per select bit |
| sel_i | input | N | Select vector; bit k enables bus k; the highest set index has priority |
| bus_o | output | W | Selected bus, or zero when no select bit is set |

## Verification
Single-hot selects are walked across every index to show that each bus is wired to its own select bit. Multi-hot selects, both random and adjacent pairs, distinguish the highest-index winner from a lowest-index or OR-merged result. All-zero selects with non-zero data show that an idle select does not leak a default bus. Further tests change the data on losing and deselected buses while the select stays fixed, and check that the output does not move. Data patterns with distinct per-lane values expose any lane that is steered by the wrong select.

// File: rtl/psel_stage.sv
module psel_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         s_i,
  output logic [W-1:0] y_o
);

  // one gate pair per lane, shared control
  for (genvar k = 0; k < W; k++) begin : g_lane
    assign y_o[k] = (a_i[k] & ~s_i) | (b_i[k] & s_i);
  end

  always_comb begin
    if (s_i) begin
      assert_stage_take_b_R6: assert (y_o == b_i)
        else $error("stage passed running value while control high");
    end else begin
      assert_stage_keep_a_R6: assert (y_o == a_i)
        else $error("stage passed bus while control low");
    end
  end

endmodule

// File: rtl/prio_bus_sel.sv
module prio_bus_sel #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0][W-1:0] bus_i,
  input  logic [N-1:0]        sel_i,
  output logic [W-1:0]        bus_o
);

  localparam int NSTG = N + 1;

  initial begin
    assert_param_n_R1: assert (N >= 1) else $error("N must be at least 1");
  end

  logic [NSTG-1:0][W-1:0] acc;

  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    psel_stage #(.W(W)) u_stage (
      .a_i (acc[i]),
      .b_i (bus_i[i]),
      .s_i (sel_i[i]),
      .y_o (acc[i+1])
    );
  end

  assign bus_o = acc[NSTG-1];

  always_comb begin
    if (sel_i == '0) begin
      assert_clear_zero_R3: assert (bus_o == '0)
        else $error("output not zero with no select");
    end
    for (int i = 0; i < N; i++) begin
      // bit i is the highest set select bit
      if ((sel_i >> i) == N'(1)) begin
        assert_top_wins_R2: assert (bus_o == bus_i[i])
          else $error("output is not the highest selected bus");
      end
    end
    if (sel_i[N-1]) begin
      assert_msb_override_R4: assert (bus_o == bus_i[N-1])
        else $error("top bus lost priority");
    end
  end

endmodule

// File: tb/tb_prio_bus_sel.sv
module tb_prio_bus_sel;

  localparam int NB = 6;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [NB-1:0][WB-1:0] bus_i;
  logic [NB-1:0]         sel_i;
  logic [WB-1:0]         bus_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  prio_bus_sel #(.N(NB), .W(WB)) dut (
    .bus_i (bus_i),
    .sel_i (sel_i),
    .bus_o (bus_o)
  );

  function automatic logic [WB-1:0] model(input logic [NB-1:0][WB-1:0] b,
                                          input logic [NB-1:0] s);
    for (int i = NB - 1; i >= 0; i--) if (s[i]) return b[i];
    return '0;
  endfunction

  task automatic check(input string req, input logic [WB-1:0] got,
                       input logic [WB-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: sel=%b got=%h exp=%h", req, sel_i, got, exp);
    end
  endtask

  task automatic apply(input logic [NB-1:0][WB-1:0] b, input logic [NB-1:0] s);
    @(negedge clk);
    bus_i = b;
    sel_i = s;
    #2;
  endtask

  task automatic rand_data(output logic [NB-1:0][WB-1:0] b);
    for (int i = 0; i < NB; i++) b[i] = WB'($urandom);
  endtask

  task automatic t_reset_state;
    apply('0, '0);
    check("R3", bus_o, '0);
  endtask

  task automatic t_single_hot;
    logic [NB-1:0][WB-1:0] b;
    for (int i = 0; i < NB; i++) b[i] = WB'(8'h11 * (i + 1)) ^ WB'(8'h80);
    for (int k = 0; k < NB; k++) begin
      apply(b, NB'(1) << k);
      check("R1", bus_o, b[k]);
    end
  endtask

  task automatic t_multi_hot;
    logic [NB-1:0][WB-1:0] b;
    logic [NB-1:0] s;
    for (int n = 0; n < 40; n++) begin
      rand_data(b);
      s = NB'($urandom);
      if ($countones(s) < 2) s = s | NB'(3);
      apply(b, s);
      check("R2", bus_o, model(b, s));
    end
    for (int k = 0; k < NB - 1; k++) begin
      rand_data(b);
      apply(b, NB'(3) << k);
      check("R2", bus_o, b[k+1]);
    end
  endtask

  task automatic t_all_clear;
    logic [NB-1:0][WB-1:0] b;
    for (int n = 0; n < 4; n++) begin
      rand_data(b);
      b[0] = '1;
      apply(b, '0);
      check("R3", bus_o, '0);
    end
  endtask

  task automatic t_lower_ignored;
    logic [NB-1:0][WB-1:0] b;
    logic [WB-1:0] first;
    rand_data(b);
    apply(b, NB'(1) << (NB - 2) | NB'(5));
    first = bus_o;
    check("R4", first, b[NB-2]);
    for (int i = 0; i < NB - 2; i++) b[i] = ~b[i];
    apply(b, sel_i);
    check("R4", bus_o, first);
  endtask

  task automatic t_unselected_ignored;
    logic [NB-1:0][WB-1:0] b;
    rand_data(b);
    apply(b, NB'(2));
    check("R5", bus_o, b[1]);
    b[NB-1] = ~b[NB-1];
    b[NB-2] = ~b[NB-2];
    b[0]    = ~b[0];
    apply(b, NB'(2));
    check("R5", bus_o, b[1]);
  endtask

  task automatic t_lanes_comb;
    logic [NB-1:0][WB-1:0] b;
    for (int i = 0; i < NB; i++) b[i] = (i % 2 == 0) ? WB'(8'hA5) : WB'(8'h5A);
    apply(b, NB'(1));
    check("R6", bus_o, WB'(8'hA5));
    // change without waiting for any edge
    sel_i = NB'(2);
    #1;
    check("R6", bus_o, WB'(8'h5A));
    bus_i[1] = WB'(8'hC3);
    #1;
    check("R6", bus_o, WB'(8'hC3));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got=%0d exp<=100000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bus_i = '0;
    sel_i = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_single_hot();
    t_multi_hot();
    t_all_clear();
    t_lower_ignored();
    t_unselected_ignored();
    t_lanes_comb();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule